// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control front end of a programmable-gain amplifier. A host writes a 7-bit control word over a write-only three-wire bus: an active-low select, a serial clock and a data line. The block samples all three pins with a fast system clock and finds serial clock edges from the synchronized samples. It shifts the data in least significant bit first. When the select line rises after exactly seven clock edges, the block copies the word into an output latch. The latched word drives the amplifier until the next valid transfer.

The low six bits of the latched word are a gain code. Codes 0 to 58 give -30 dB to +28 dB in 1 dB steps, and any higher code is clamped to 58. The top bit is an active-low sleep flag. The block combines the latch with a hardware power-enable input and a transmit-enable input and reports one of four modes. Pulling power-enable low wipes the stored word. After power returns, the block stays asleep until a new word is written.

Top module: `gain_ctrl_rx`

## Requirements
- R1: After reset, word_out is 0, gain_code is 0, mode_out is sleep (1) and path_on is 0.
- R2: A transfer shifts sdata_in on each rising sclk_in edge while cs_n_in is low, least significant bit first. On the rising edge of cs_n_in the seven bits appear on word_out, with bit 6 as the sleep flag and bits 5..0 as the gain code.
- R3: A latched bit 6 of 0 gives mode sleep (1). A latched bit 6 of 1 leaves sleep.
- R4: While cs_n_in is low, word_out keeps the previously latched word.
- R5: If cs_n_in rises after any number of sclk_in rising edges other than 7, word_out keeps its old value.
- R6: Rising edges of sclk_in while cs_n_in is high have no effect on word_out or on the next transfer.
- R7: path_on is 1 only when hw_on, tx_en and latched bit 6 are all 1. In that case mode_out is active (3).
- R8: gain_code equals bits 5..0 of word_out when that value is 58 or less, and 58 otherwise.
- R9: With tx_en low (and hw_on high, bit 6 set), mode_out is tx-off (2). Transfers are still accepted and latched.
- R10: With hw_on low, mode_out is off (0), path_on is 0 and word_out is cleared; transfers are ignored. After hw_on returns high, the block reads as sleep with word 0 until a new word is written.
- R11: Mode priority is off over sleep over tx-off over active, encoded 0, 1, 2, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Serial select, active low, asynchronous |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| hw_on | input | 1 | Hardware power enable; low switches off and clears the word |
| tx_en | input | 1 | Transmit enable; low disables only the signal path |
| word_out | output | 7 | Latched control word |
| gain_code | output | 6 | Clamped gain code, 0..58 |
| mode_out | output | 2 | 0 off, 1 sleep, 2 tx-off, 3 active |
| path_on | output | 1 | Signal path enabled |

## Verification
The bench aims at transfers of the wrong length: a 4-bit transfer aborted early and an 8-bit overrun. A design that latched without counting would show a shifted or partial word there. It toggles the serial clock with select high and then sends a full word. A design that kept counting outside a transfer would reject the word or corrupt it. It writes codes 63 and 58 to show the clamp edge. It writes during tx-off to show latching still works, and during power-off to show writes are ignored. It then checks that the word is gone after power returns. A design that only masked the outputs would bring the old gain back.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int WORD_W   = 7;
    localparam int GAIN_W   = 6;
    localparam int GAIN_MAX = 58;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_SLEEP  = 2'd1,
        MODE_TXOFF  = 2'd2,
        MODE_ACTIVE = 2'd3
    } mode_e;

    // awake is the active-low sleep flag: 1 means not sleeping
    typedef struct packed {
        logic              awake;
        logic [GAIN_W-1:0] code;
    } ctrl_word_t;

    function automatic logic [GAIN_W-1:0] clamp_gain(input logic [GAIN_W-1:0] c);
        logic [GAIN_W-1:0] lim;
        lim = GAIN_W'(GAIN_MAX);
        return (c > lim) ? lim : c;
    endfunction

endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= RST_VAL;
            else     stage[g] <= stage[g-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gcr_shifter.sv
module gcr_shifter
    import gcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdata,
    output ctrl_word_t word_q
);
    localparam int CNT_SAT = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    logic              cs_d, sclk_d;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              sclk_rise, cs_rise;

    assign sclk_rise = sclk & ~sclk_d;
    assign cs_rise   = cs_n & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_n;
            sclk_d <= sclk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr     <= '0;
            cnt    <= '0;
            word_q <= '0;
        end else if (cs_n) begin
            cnt <= '0;
            if (cs_rise && cnt == CNT_W'(WORD_W))
                word_q <= ctrl_word_t'(sr);
        end else if (sclk_rise) begin
            sr <= {sdata, sr[WORD_W-1:1]};
            if (cnt != CNT_W'(CNT_SAT))
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gcr_mode.sv
module gcr_mode
    import gcr_pkg::*;
(
    input  logic              hw_on,
    input  logic              tx_en,
    input  ctrl_word_t        word,
    output mode_e             mode,
    output logic [GAIN_W-1:0] gain
);
    always_comb begin
        if (!hw_on)           mode = MODE_OFF;
        else if (!word.awake) mode = MODE_SLEEP;
        else if (!tx_en)      mode = MODE_TXOFF;
        else                  mode = MODE_ACTIVE;
    end

    assign gain = clamp_gain(word.code);
endmodule

// File: rtl/gain_ctrl_rx.sv
module gain_ctrl_rx
    import gcr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              hw_on,
    input  logic              tx_en,
    output logic [WORD_W-1:0] word_out,
    output logic [GAIN_W-1:0] gain_code,
    output logic [1:0]        mode_out,
    output logic              path_on
);
    logic       cs_s, sclk_s, sdata_s;
    ctrl_word_t word_q;
    mode_e      mode;

    gcr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_in, sclk_in, sdata_in}),
        .q   ({cs_s, sclk_s, sdata_s})
    );

    gcr_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (~hw_on),
        .cs_n   (cs_s),
        .sclk   (sclk_s),
        .sdata  (sdata_s),
        .word_q (word_q)
    );

    gcr_mode u_mode (
        .hw_on (hw_on),
        .tx_en (tx_en),
        .word  (word_q),
        .mode  (mode),
        .gain  (gain_code)
    );

    assign word_out = word_q;
    assign mode_out = mode;
    assign path_on  = (mode == MODE_ACTIVE);
endmodule

// File: rtl/gain_ctrl_rx_chk.sv
module gain_ctrl_rx_chk
    import gcr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hw_on,
    input logic              tx_en,
    input logic              cs_s,
    input logic [WORD_W-1:0] word_out,
    input logic [GAIN_W-1:0] gain_code,
    input logic [1:0]        mode_out,
    input logic              path_on
);
    // R4: no latch change while the synchronized select is low
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (hw_on && !cs_s) |=> $stable(word_out));

    // R10: power-off forces the off mode
    p_off_mode_r10: assert property (@(posedge clk) disable iff (rst)
        !hw_on |-> (mode_out == MODE_OFF && !path_on));

    // R10: power-off wipes the latch
    p_wipe_r10: assert property (@(posedge clk) disable iff (rst)
        !hw_on |=> (word_out == '0));

    // R7: path enabled only with all three conditions
    p_path_r7: assert property (@(posedge clk) disable iff (rst)
        path_on |-> (hw_on && tx_en && word_out[WORD_W-1]));

    // R3: cleared sleep flag means sleep when powered
    p_sleep_r3: assert property (@(posedge clk) disable iff (rst)
        (hw_on && !word_out[WORD_W-1]) |-> (mode_out == MODE_SLEEP));

    // R8: gain never above the ceiling
    p_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        gain_code <= GAIN_W'(GAIN_MAX));
endmodule

bind gain_ctrl_rx gain_ctrl_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hw_on     (hw_on),
    .tx_en     (tx_en),
    .cs_s      (cs_s),
    .word_out  (word_out),
    .gain_code (gain_code),
    .mode_out  (mode_out),
    .path_on   (path_on)
);

// File: tb/gain_ctrl_rx_bench.sv
module gain_ctrl_rx_bench;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n_in = 1'b1, sclk_in = 1'b0, sdata_in = 1'b0;
    logic       hw_on = 1'b1, tx_en = 1'b1;
    logic [6:0] word_out;
    logic [5:0] gain_code;
    logic [1:0] mode_out;
    logic       path_on;

    always #10 clk = ~clk;

    gain_ctrl_rx u_gain_ctrl_rx (
        .clk(clk), .rst(rst), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
        .sdata_in(sdata_in), .hw_on(hw_on), .tx_en(tx_en),
        .word_out(word_out), .gain_code(gain_code),
        .mode_out(mode_out), .path_on(path_on)
    );

    typedef struct {
        logic [6:0] w;
        logic [5:0] g;
        logic [1:0] m;
        logic       p;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;
    int    checks = 0, fails = 0;
    bit    done = 0;
    logic [6:0] m_word = '0;

    function automatic logic [1:0] exp_mode(logic [6:0] w, logic h, logic t);
        if (!h)        return 2'd0;
        else if (!w[6]) return 2'd1;
        else if (!t)    return 2'd2;
        else            return 2'd3;
    endfunction

    task automatic push_chk(input string tag);
        item_t it;
        it.w   = m_word;
        it.g   = (m_word[5:0] > 6'd58) ? 6'd58 : m_word[5:0];
        it.m   = exp_mode(m_word, hw_on, tx_en);
        it.p   = (it.m == 2'd3);
        it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            item_t it;
            @(chk_ev);
            @(negedge clk);
            it = exp_q.pop_front();
            cmp(it.tag, "word", int'(word_out), int'(it.w));
            cmp(it.tag, "gain", int'(gain_code), int'(it.g));
            cmp(it.tag, "mode", int'(mode_out), int'(it.m));
            cmp(it.tag, "path", int'(path_on), int'(it.p));
        end
    end

    // driver: n bits LSB first; raise select at the end if fin
    task automatic send_bits(input logic [7:0] d, input int n, input bit fin);
        @(negedge clk);
        cs_n_in = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdata_in = d[i];
            repeat (HALF) @(negedge clk);
            sclk_in = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (fin) begin
            cs_n_in = 1'b1;
            repeat (6) @(negedge clk);
            if (n == 7 && hw_on) m_word = d[6:0];
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        push_chk("R1 reset");

        send_bits(8'h45, 7, 1); push_chk("R2 R7 word 0x45");
        send_bits(8'h0A, 7, 1); push_chk("R3 sleep flag low");
        send_bits(8'h7F, 7, 1); push_chk("R8 clamp 63");
        send_bits(8'h7A, 7, 1); push_chk("R8 code 58");
        send_bits(8'h40, 7, 1); push_chk("R8 code 0 R3 awake");

        send_bits(8'h23, 4, 0); push_chk("R4 hold during transfer");
        cs_n_in = 1'b1; repeat (6) @(negedge clk);
        push_chk("R5 short transfer dropped");
        send_bits(8'h95, 8, 1); push_chk("R5 long transfer dropped");

        for (int i = 0; i < 5; i++) begin
            sdata_in = i[0];
            repeat (HALF) @(negedge clk); sclk_in = 1'b1;
            repeat (HALF) @(negedge clk); sclk_in = 1'b0;
        end
        push_chk("R6 idle clocks ignored");
        send_bits(8'h55, 7, 1); push_chk("R6 next transfer intact");

        tx_en = 1'b0; @(negedge clk); push_chk("R9 R11 tx off");
        send_bits(8'h61, 7, 1); push_chk("R9 latch during tx off");
        tx_en = 1'b1; @(negedge clk); push_chk("R7 active again");

        hw_on = 1'b0; @(negedge clk); m_word = '0; @(negedge clk);
        push_chk("R10 R11 power off");
        send_bits(8'h7C, 7, 1); push_chk("R10 write ignored when off");
        hw_on = 1'b1; repeat (2) @(negedge clk);
        push_chk("R10 sleep after power return");
        send_bits(8'h4C, 7, 1); push_chk("R10 rewrite after power");

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule